// File: doc/BRIEF.md
# Indirect Register and Buffer Access Port

This block is the host-facing slave interface of a host controller. A host processor sees only two 16-bit locations: an address port and a data port. It first writes a register selector to the address port, then moves data through the data port. Bit 7 of the selector marks the access as a write. Bits 6:0 name the register. The one 32-bit register, the buffer window, is moved as two 16-bit data-port accesses.

The buffer window gives access to the controller's internal packet memory. It holds a byte start offset and a remaining byte count. Once it is loaded, repeated data-port accesses to the stream register read or write consecutive 16-bit words of the memory. When the count runs out, an end-of-transfer flag is raised in a status register. The host clears that flag by writing a one to it. The block also holds a chip identity register, a scratch register and a keyed software-reset register. The protocol engine sits outside this block. It supplies only the frame tick that sets the start-of-frame status bit.

Top module: `hc_access_port`

## Requirements
- R1: A write to the address port stores bits 7:0 of the data. Bit 7 set makes later data-port writes take effect and data-port reads return zero. Bit 7 clear makes data-port reads return register contents and data-port writes take no effect. Bits 6:0 select the register.
- R2: A read of the address port always returns 0x0000, so the stored selector cannot be read back.
- R3: The window register (number 0x32) takes two consecutive data-port accesses, low half first, then high half. The low half is the byte offset. It is taken modulo the buffer size with bit 0 cleared, and it reads back as the current offset. The high half is the byte count and reads back as the remaining count. Any address-port write restarts at the low half.
- R4: A count written to the high half is rounded up to an even value (5 becomes 6).
- R5: Each data-port access to the stream register (number 0x45) while the remaining count is non-zero has three effects. It moves one 16-bit word at the current offset, it advances the offset by 2 (wrapping at the buffer size), and it reduces the count by 2.
- R6: While the remaining count is zero, a stream write leaves the memory unchanged and a stream read returns 0x0000.
- R7: The access that brings the remaining count to zero sets bit 3 (end of transfer) of the status register (number 0x24).
- R8: A frame_tick_i pulse sets bit 0 (start of frame) of the status register. Writing the status register clears every bit written as one and leaves bits written as zero unchanged. A set in the same cycle as a clear wins.
- R9: The chip identity register (number 0x27) reads {0x36, CHIP_REV}. Writes to it have no effect.
- R10: The scratch register (number 0x28) is a plain 16-bit read/write register and is zero after reset.
- R11: Writing 0x00F6 to the reset register (number 0x29) clears the scratch register, the status register, the window offset and the count. It also pulses soft_rst_o for one cycle. Other values have no effect. Reading the reset register returns 0x0000.
- R12: After reset, the chip identity register reads its fixed value, and the scratch register, the status register and both window halves read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick_i | input | 1 | One-cycle start-of-frame event from the protocol engine |
| bus_port_i | input | 1 | 1 selects the address port, 0 selects the data port |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid in the cycle of the read strobe |
| soft_rst_o | output | 1 | One-cycle pulse after a keyed software reset |

## Verification
The bench builds the block with a 64-byte buffer and an identity revision of 0x5A. The small buffer lets a short stream starting at offset 0x3E cross the top of memory and land on offset 0x02. That exercises the wrap of the offset without thousands of accesses. The revision value makes the low byte of the identity register differ from its reset value and from the scratch contents, so a wrong read mux shows. The scoreboard also checks stream reads at count zero, selectors whose direction does not match the strobe, and a status clear that coincides with a frame tick.

// File: rtl/hcap_pkg.sv
package hcap_pkg;
   // Register numbers (host software decodes these)
   localparam logic [6:0] RN_STATUS  = 7'h24;
   localparam logic [6:0] RN_CHIPID  = 7'h27;
   localparam logic [6:0] RN_SCRATCH = 7'h28;
   localparam logic [6:0] RN_SWRST   = 7'h29;
   localparam logic [6:0] RN_WINDOW  = 7'h32;
   localparam logic [6:0] RN_STREAM  = 7'h45;

   localparam logic [15:0] SWRST_KEY = 16'h00F6;
   localparam logic [7:0]  CHIPID_HI = 8'h36;

   localparam int ST_SOF = 0;
   localparam int ST_EOT = 3;
   localparam int ST_W   = 4;

   // Decoded data-port access
   typedef struct packed {
      logic       wr;
      logic       rd;
      logic [6:0] num;
      logic       hi;
   } hcap_acc_t;

   function automatic logic is_wide(input logic [6:0] n);
      return n == RN_WINDOW;
   endfunction
endpackage

// File: rtl/hcap_addr_ctl.sv
module hcap_addr_ctl
   import hcap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_port_i,
   input  logic       bus_wr_i,
   input  logic       bus_rd_i,
   input  logic [7:0] sel_i,
   output hcap_acc_t  acc_o
);
   logic [7:0] addr_q;
   logic       half_q;
   logic       wflag;
   logic       data_acc;

   assign wflag    = addr_q[7];
   assign data_acc = !bus_port_i;

   always_comb begin
      acc_o.wr  = data_acc && bus_wr_i && wflag;
      acc_o.rd  = data_acc && bus_rd_i && !wflag;
      acc_o.num = addr_q[6:0];
      acc_o.hi  = half_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         half_q <= 1'b0;
      end else if (bus_port_i && bus_wr_i) begin
         addr_q <= sel_i;
         half_q <= 1'b0;
      end else if ((acc_o.wr || acc_o.rd) && is_wide(addr_q[6:0])) begin
         half_q <= !half_q;
      end
   end

   // R3
   half_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_port_i && bus_wr_i) |=> !half_q);

   // R3
   half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_port_i && (bus_wr_i || bus_rd_i) && is_wide(acc_o.num) &&
       (bus_wr_i ? wflag : !wflag)) |=> (half_q != $past(half_q)));
endmodule

// File: rtl/hcap_buf_window.sv
module hcap_buf_window #(
   parameter int BUF_BYTES = 4096,
   parameter int DW        = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          ld_off_i,
   input  logic          ld_cnt_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          wr_i,
   input  logic          rd_i,
   output logic [DW-1:0] off_o,
   output logic [DW-1:0] cnt_o,
   output logic [DW-1:0] rdata_o,
   output logic          done_o
);
   localparam int WORDS = BUF_BYTES / 2;
   localparam int IW    = $clog2(WORDS);
   localparam int OW    = IW + 1;

   generate
      if (DW != 16) begin : g_bad_dw
         $error("hcap_buf_window: data width must be 16");
      end
      if (OW >= DW) begin : g_bad_size
         $error("hcap_buf_window: buffer too large for offset field");
      end
   endgenerate

   logic [DW-1:0] mem [WORDS];
   logic [IW-1:0] idx_q;
   logic [DW-1:0] cnt_q;
   logic          busy;
   logic          step;

   assign busy   = cnt_q != '0;
   assign step   = (wr_i || rd_i) && busy;
   assign done_o = step && (cnt_q == DW'(2));
   assign off_o  = {{(DW-OW){1'b0}}, idx_q, 1'b0};
   assign cnt_o  = cnt_q;
   assign rdata_o = busy ? mem[idx_q] : '0;

   always_ff @(posedge clk) begin
      if (wr_i && busy) mem[idx_q] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         cnt_q <= '0;
      end else if (clr_i) begin
         idx_q <= '0;
         cnt_q <= '0;
      end else if (ld_off_i) begin
         idx_q <= wdata_i[IW:1];
      end else if (ld_cnt_i) begin
         cnt_q <= wdata_i + {{(DW-1){1'b0}}, wdata_i[0]};
      end else if (step) begin
         idx_q <= idx_q + IW'(1);
         cnt_q <= cnt_q - DW'(2);
      end
   end

   // R4
   cnt_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_q[0]);

   // R5
   win_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr_i && !ld_off_i && !ld_cnt_i) |=>
         (cnt_q == $past(cnt_q) - DW'(2)) && (idx_q == $past(idx_q) + IW'(1)));

   // R6
   win_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !clr_i && !ld_off_i && !ld_cnt_i) |=> $stable(idx_q));
endmodule

// File: rtl/hcap_status.sv
module hcap_status #(
   parameter int SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_all_i,
   input  logic [SW-1:0] set_i,
   input  logic [SW-1:0] w1c_i,
   output logic [SW-1:0] stat_o
);
   generate
      if (SW < 1) begin : g_bad_sw
         $error("hcap_status: needs at least one bit");
      end
      for (genvar b = 0; b < SW; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            stat_o[b] <= 1'b0;
            else if (clr_all_i)    stat_o[b] <= 1'b0;
            else if (set_i[b])     stat_o[b] <= 1'b1;
            else if (w1c_i[b])     stat_o[b] <= 1'b0;
         end

         // R8
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[b] && !clr_all_i) |=> stat_o[b]);

         // R8
         w1c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[b] && !w1c_i[b] && !clr_all_i) |=> $stable(stat_o[b]));
      end
   endgenerate
endmodule

// File: rtl/hc_access_port.sv
module hc_access_port
   import hcap_pkg::*;
#(
   parameter int         BUF_BYTES = 4096,
   parameter logic [7:0] CHIP_REV  = 8'h01
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        frame_tick_i,
   input  logic        bus_port_i,
   input  logic        bus_wr_i,
   input  logic        bus_rd_i,
   input  logic [15:0] bus_wdata_i,
   output logic [15:0] bus_rdata_o,
   output logic        soft_rst_o
);
   localparam int DW = 16;

   generate
      if ((BUF_BYTES & (BUF_BYTES - 1)) != 0 || BUF_BYTES < 4) begin : g_bad_buf
         $error("hc_access_port: BUF_BYTES must be a power of two >= 4");
      end
   endgenerate

   hcap_acc_t     acc;
   logic          swrst;
   logic          ld_off, ld_cnt;
   logic          str_wr, str_rd;
   logic          win_done;
   logic [DW-1:0] win_off, win_cnt, win_rdata;
   logic [ST_W-1:0] st_set, st_w1c, stat;
   logic [DW-1:0] scratch_q;
   logic          soft_q;

   hcap_addr_ctl u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_port_i (bus_port_i),
      .bus_wr_i   (bus_wr_i),
      .bus_rd_i   (bus_rd_i),
      .sel_i      (bus_wdata_i[7:0]),
      .acc_o      (acc)
   );

   assign swrst  = acc.wr && acc.num == RN_SWRST && bus_wdata_i == SWRST_KEY;
   assign ld_off = acc.wr && acc.num == RN_WINDOW && !acc.hi;
   assign ld_cnt = acc.wr && acc.num == RN_WINDOW && acc.hi;
   assign str_wr = acc.wr && acc.num == RN_STREAM;
   assign str_rd = acc.rd && acc.num == RN_STREAM;

   hcap_buf_window #(.BUF_BYTES(BUF_BYTES), .DW(DW)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (swrst),
      .ld_off_i (ld_off),
      .ld_cnt_i (ld_cnt),
      .wdata_i  (bus_wdata_i),
      .wr_i     (str_wr),
      .rd_i     (str_rd),
      .off_o    (win_off),
      .cnt_o    (win_cnt),
      .rdata_o  (win_rdata),
      .done_o   (win_done)
   );

   always_comb begin
      st_set         = '0;
      st_set[ST_SOF] = frame_tick_i;
      st_set[ST_EOT] = win_done;
      st_w1c         = (acc.wr && acc.num == RN_STATUS) ? bus_wdata_i[ST_W-1:0] : '0;
   end

   hcap_status #(.SW(ST_W)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_all_i (swrst),
      .set_i     (st_set),
      .w1c_i     (st_w1c),
      .stat_o    (stat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scratch_q <= '0;
         soft_q    <= 1'b0;
      end else begin
         soft_q <= swrst;
         if (swrst)
            scratch_q <= '0;
         else if (acc.wr && acc.num == RN_SCRATCH)
            scratch_q <= bus_wdata_i;
      end
   end

   assign soft_rst_o = soft_q;

   always_comb begin
      bus_rdata_o = '0;
      if (acc.rd) begin
         unique case (acc.num)
            RN_STATUS:  bus_rdata_o = {{(DW-ST_W){1'b0}}, stat};
            RN_CHIPID:  bus_rdata_o = {CHIPID_HI, CHIP_REV};
            RN_SCRATCH: bus_rdata_o = scratch_q;
            RN_WINDOW:  bus_rdata_o = acc.hi ? win_cnt : win_off;
            RN_STREAM:  bus_rdata_o = win_rdata;
            default:    bus_rdata_o = '0;
         endcase
      end
   end

   // R2
   addr_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && bus_port_i) |-> (bus_rdata_o == '0));

   // R7
   eot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_done |=> stat[ST_EOT]);

   // R9
   chipid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.rd && acc.num == RN_CHIPID) |-> (bus_rdata_o[15:8] == 8'h36));

   // R11
   swrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swrst |=> (soft_rst_o && scratch_q == '0 && stat == '0 && win_cnt == '0));

   // R11
   soft_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |=> !soft_rst_o);
endmodule

// File: tb/hc_access_port_bench.sv
module hc_access_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_tick_i = 1'b0;
   logic        bus_port_i = 1'b0;
   logic        bus_wr_i = 1'b0;
   logic        bus_rd_i = 1'b0;
   logic [15:0] bus_wdata_i = '0;
   logic [15:0] bus_rdata_o;
   logic        soft_rst_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [15:0] q_exp[$];
   string       q_tag[$];

   always #4 clk = !clk;

   hc_access_port #(.BUF_BYTES(64), .CHIP_REV(8'h5A)) u_hc_access_port (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_tick_i (frame_tick_i),
      .bus_port_i   (bus_port_i),
      .bus_wr_i     (bus_wr_i),
      .bus_rd_i     (bus_rd_i),
      .bus_wdata_i  (bus_wdata_i),
      .bus_rdata_o  (bus_rdata_o),
      .soft_rst_o   (soft_rst_o)
   );

   // Monitor: pops expected read data and compares mid-cycle
   always @(negedge clk) begin
      if (rst_n && bus_rd_i) begin
         n_chk++;
         if (q_exp.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected read: actual %h expected none", bus_rdata_o);
         end else begin
            logic [15:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            if (bus_rdata_o !== e) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", t, bus_rdata_o, e);
            end
         end
      end
   end

   task automatic idle();
      bus_wr_i = 1'b0; bus_rd_i = 1'b0; frame_tick_i = 1'b0;
   endtask

   task automatic addr_wr(input logic [7:0] v);
      @(posedge clk); #1;
      bus_port_i = 1'b1; bus_wr_i = 1'b1; bus_wdata_i = {8'h00, v};
      @(posedge clk); #1; idle();
   endtask

   task automatic data_wr(input logic [15:0] v);
      @(posedge clk); #1;
      bus_port_i = 1'b0; bus_wr_i = 1'b1; bus_wdata_i = v;
      @(posedge clk); #1; idle();
   endtask

   task automatic exp_rd(input logic port, input logic [15:0] e, input string t);
      q_exp.push_back(e);
      q_tag.push_back(t);
      @(posedge clk); #1;
      bus_port_i = port; bus_rd_i = 1'b1;
      @(posedge clk); #1; idle();
   endtask

   task automatic data_rd(input logic [15:0] e, input string t);
      exp_rd(1'b0, e, t);
   endtask

   task automatic tick();
      @(posedge clk); #1; frame_tick_i = 1'b1;
      @(posedge clk); #1; idle();
   endtask

   task automatic load_win(input logic [15:0] off, input logic [15:0] cnt);
      addr_wr(8'hB2);
      data_wr(off);
      data_wr(cnt);
   endtask

   task automatic direct(input logic ok, input logic [15:0] act, input logic [15:0] e,
                         input string t);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", t, act, e);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R12 reset state
      addr_wr(8'h27); data_rd(16'h365A, "R12 chip id after reset");
      addr_wr(8'h28); data_rd(16'h0000, "R12 R10 scratch reset");
      addr_wr(8'h24); data_rd(16'h0000, "R12 status reset");
      addr_wr(8'h32); data_rd(16'h0000, "R12 window offset reset");
      data_rd(16'h0000, "R12 window count reset");

      // R2 address port not readable
      addr_wr(8'h28);
      exp_rd(1'b1, 16'h0000, "R2 address read");

      // R10 scratch
      addr_wr(8'hA8); data_wr(16'h1234);
      addr_wr(8'h28); data_rd(16'h1234, "R10 scratch readback");

      // R1 direction mismatches
      data_wr(16'hBEEF);
      data_rd(16'h1234, "R1 write with read selector ignored");
      addr_wr(8'hA8); data_rd(16'h0000, "R1 read with write selector");

      // R9 chip id not writable
      addr_wr(8'hA7); data_wr(16'h0000);
      addr_wr(8'h27); data_rd(16'h365A, "R9 chip id after write");

      // R5 single word at 0x16, R7 EOT
      load_win(16'h0016, 16'h0002);
      addr_wr(8'hC5); data_wr(16'h4444);
      addr_wr(8'h24); data_rd(16'h0008, "R7 eot after one word");
      addr_wr(8'hA4); data_wr(16'h0001);
      addr_wr(8'h24); data_rd(16'h0008, "R8 clear of other bit keeps eot");
      addr_wr(8'hA4); data_wr(16'h0008);
      addr_wr(8'h24); data_rd(16'h0000, "R8 eot cleared by one");

      // R4 odd count, R3 readback
      load_win(16'h0010, 16'h0005);
      addr_wr(8'h32);
      data_rd(16'h0010, "R3 offset readback");
      data_rd(16'h0006, "R4 count rounded up");
      addr_wr(8'hC5);
      data_wr(16'h1111); data_wr(16'h2222); data_wr(16'h3333);
      addr_wr(8'h24); data_rd(16'h0008, "R7 eot after three words");
      addr_wr(8'hC5); data_wr(16'h9999);
      addr_wr(8'h32);
      data_rd(16'h0016, "R5 offset advanced by 6");
      data_rd(16'h0000, "R5 count exhausted");

      // R5 R6 read back stream
      load_win(16'h0010, 16'h0008);
      addr_wr(8'h45);
      data_rd(16'h1111, "R5 word 0");
      data_rd(16'h2222, "R5 word 1");
      data_rd(16'h3333, "R5 word 2");
      data_rd(16'h4444, "R6 word 3 untouched by idle write");
      data_rd(16'h0000, "R6 read at count zero");

      // R5 wrap at buffer end
      load_win(16'h003E, 16'h0004);
      addr_wr(8'hC5); data_wr(16'hAAAA); data_wr(16'hBBBB);
      addr_wr(8'h32); data_rd(16'h0002, "R5 offset wrapped");
      load_win(16'h003E, 16'h0004);
      addr_wr(8'h45);
      data_rd(16'hAAAA, "R5 wrap word top");
      data_rd(16'hBBBB, "R5 wrap word bottom");

      // R3 half restart on address write
      addr_wr(8'hB2); data_wr(16'h0020);
      addr_wr(8'hB2); data_wr(16'h0030);
      addr_wr(8'h32);
      data_rd(16'h0030, "R3 restart low half");
      data_rd(16'h0000, "R3 count untouched");

      // R8 frame tick, set wins
      addr_wr(8'hA4); data_wr(16'h0008);
      tick();
      addr_wr(8'h24); data_rd(16'h0001, "R8 sof set by tick");
      addr_wr(8'hA4);
      @(posedge clk); #1;
      bus_port_i = 1'b0; bus_wr_i = 1'b1; bus_wdata_i = 16'h0001; frame_tick_i = 1'b1;
      @(posedge clk); #1; idle();
      addr_wr(8'h24); data_rd(16'h0001, "R8 set wins over clear");
      addr_wr(8'hA4); data_wr(16'h0001);
      addr_wr(8'h24); data_rd(16'h0000, "R8 sof cleared");

      // R11 soft reset
      addr_wr(8'hA8); data_wr(16'h5678);
      load_win(16'h0008, 16'h0004);
      tick();
      addr_wr(8'hA9); data_wr(16'h00F5);
      direct(soft_rst_o == 1'b0, {15'd0, soft_rst_o}, 16'h0000, "R11 wrong key no pulse");
      addr_wr(8'h28); data_rd(16'h5678, "R11 wrong key keeps scratch");
      addr_wr(8'h29); data_rd(16'h0000, "R11 reset register reads zero");
      addr_wr(8'hA9); data_wr(16'h00F6);
      direct(soft_rst_o == 1'b1, {15'd0, soft_rst_o}, 16'h0001, "R11 pulse after key");
      @(posedge clk); #1;
      direct(soft_rst_o == 1'b0, {15'd0, soft_rst_o}, 16'h0000, "R11 pulse one cycle");
      addr_wr(8'h28); data_rd(16'h0000, "R11 scratch cleared");
      addr_wr(8'h24); data_rd(16'h0000, "R11 status cleared");
      addr_wr(8'h32);
      data_rd(16'h0000, "R11 offset cleared");
      data_rd(16'h0000, "R11 count cleared");

      repeat (2) @(posedge clk);
      if (q_exp.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL scoreboard: actual %0d pending expected 0", q_exp.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule